// File: doc/BRIEF.md
# Selectable-Polynomial Parallel PRBS Word Generator

This block produces a pseudo-random bit sequence for transceiver link testing. It delivers the bits as a parallel word, either 10 or 64 bits on each clock. One linear feedback shift register is unrolled so that a whole word is produced in a single cycle. The feedback polynomial is chosen at run time from five fixed patterns. Each word picks up the sequence exactly where the previous word stopped, so a downstream serializer that sends bit 0 first sees one unbroken stream.

Not every pattern is allowed at every width. Only the 9-stage pattern may run at the narrow 10-bit width. All five patterns may run at the 64-bit width. An illegal pairing is not generated. The block raises an error flag and drives zeros. A small controller holds three modes: `ST_OFF` (disabled, register held), `ST_RUN` (a word is produced every clock) and `ST_FAULT` (illegal configuration). The controller moves between them on every clock as follows:
- Any mode goes to `ST_FAULT` when the configuration is illegal.
- Otherwise any mode goes to `ST_RUN` when enable is high.
- Otherwise any mode goes to `ST_OFF`.

Top module: `prbs_word_gen`

## Requirements
- R1: `pattern_sel` codes are 0 = 1+x^6+x^7, 1 = 1+x^5+x^9, 2 = 1+x^14+x^15, 3 = 1+x^18+x^23 and 4 = 1+x^28+x^31. Codes 5, 6 and 7 are unsupported.
- R2: The serial rule is the same for every pattern. For a polynomial 1+x^T+x^N with register s, each step emits fb = s[N-1] xor s[T-1], and s becomes {s[N-2:0], fb}. Output bit i of a word is the i-th emitted bit, so bit 0 is first.
- R3: `width_sel` = 1 selects 64 bits per enabled clock. `width_sel` = 0 selects 10 bits, placed in `data_out[9:0]`, with `data_out[63:10]` at zero.
- R4: Code 1 is legal at both widths. Codes 0, 2, 3 and 4 are legal only when `width_sel` = 1.
- R5: An illegal pairing makes `config_error` high and `data_valid` low, with `data_out` at zero, after the next clock. The register state is held through the fault.
- R6: While `rst_n` is low, all outputs are zero and the register is loaded with all ones.
- R7: When `pattern_sel` differs from its value at the previous clock, the register is reseeded with all ones. The word produced on that clock is taken from the fresh seed.
- R8: Consecutive words continue the sequence without gap or overlap, including across a width change.
- R9: With `enable` low and a legal configuration, `data_valid` is low, `data_out` is zero and the register holds.
- R10: Outputs are registered. They reflect the inputs present at the preceding rising edge.
- R11: A valid word is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Advance the sequence and emit a word |
| pattern_sel | input | 3 | Polynomial code (R1) |
| width_sel | input | 1 | 1 = 64-bit word, 0 = 10-bit word |
| data_out | output | 64 | Sequence word, bit 0 first in serial order |
| data_valid | output | 1 | `data_out` holds a fresh word |
| config_error | output | 1 | Pattern and width pairing is illegal |

## Verification
The properties assume that `pattern_sel`, `width_sel` and `enable` are settled before each rising edge and that reset lasts at least one edge. The stimulus meets this by changing every input only on the falling edge. The all-zero check takes for granted that the register never becomes zero, which holds only because every reseed loads all ones. The stimulus therefore checks the reseed directly by comparing the first word after each pattern change with a model started from all ones.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int NUM_PAT = 5;
    localparam int MAX_LEN = 31;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        PAT_P7  = 3'd0,
        PAT_P9  = 3'd1,
        PAT_P15 = 3'd2,
        PAT_P23 = 3'd3,
        PAT_P31 = 3'd4
    } pat_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } mode_e;

    // register length of pattern k
    function automatic int pat_len(input int k);
        case (k)
            0:       return 7;
            1:       return 9;
            2:       return 15;
            3:       return 23;
            default: return 31;
        endcase
    endfunction

    // inner tap of pattern k
    function automatic int pat_tap(input int k);
        case (k)
            0:       return 6;
            1:       return 5;
            2:       return 14;
            3:       return 18;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/prbs_lfsr_unroll.sv
module prbs_lfsr_unroll #(
    parameter int LEN      = 7,
    parameter int TAP      = 6,
    parameter int STORE_W  = 31,
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 10
) (
    input  logic [LEN-1:0]     seed,
    output logic [WIDE_W-1:0]  word,
    output logic [STORE_W-1:0] next_wide,
    output logic [STORE_W-1:0] next_narrow
);

    logic [LEN-1:0] s;
    logic           fb;

    // unrolled serial steps; bit i of word is the i-th emitted bit
    always_comb begin
        s           = seed;
        fb          = 1'b0;
        word        = '0;
        next_wide   = '0;
        next_narrow = '0;
        for (int i = 0; i < WIDE_W; i++) begin
            fb      = s[LEN-1] ^ s[TAP-1];
            word[i] = fb;
            s       = {s[LEN-2:0], fb};
            if (i == NARROW_W - 1) begin
                next_narrow[LEN-1:0] = s;
            end
        end
        next_wide[LEN-1:0] = s;
    end

endmodule

// File: rtl/prbs_cfg_check.sv
module prbs_cfg_check
    import prbs_pkg::*;
(
    input  logic [SEL_W-1:0] pattern_sel,
    input  logic             width_sel,
    output logic             cfg_ok
);

    logic code_known;
    logic narrow_ok;

    always_comb begin
        code_known = (pattern_sel <= SEL_W'(PAT_P31));
        narrow_ok  = (pattern_sel == SEL_W'(PAT_P9));
        cfg_ok     = code_known && (width_sel || narrow_ok);
    end

endmodule

// File: rtl/prbs_mode_fsm.sv
module prbs_mode_fsm
    import prbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  cfg_ok,
    output mode_e st_d,
    output logic  run_now,
    output logic  fault_now
);

    mode_e st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = ST_OFF;
        unique case (st_q)
            ST_OFF: begin
                if (!cfg_ok)     st_d = ST_FAULT;
                else if (enable) st_d = ST_RUN;
                else             st_d = ST_OFF;
            end
            ST_RUN: begin
                if (!cfg_ok)      st_d = ST_FAULT;
                else if (!enable) st_d = ST_OFF;
                else              st_d = ST_RUN;
            end
            ST_FAULT: begin
                if (cfg_ok) st_d = enable ? ST_RUN : ST_OFF;
                else        st_d = ST_FAULT;
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_comb begin
        run_now   = (st_q == ST_RUN);
        fault_now = (st_q == ST_FAULT);
    end

endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
    import prbs_pkg::*;
#(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [2:0]        pattern_sel,
    input  logic              width_sel,
    output logic [WIDE_W-1:0] data_out,
    output logic              data_valid,
    output logic              config_error
);

    localparam int ST_W  = MAX_LEN;
    localparam int PAD_W = WIDE_W - NARROW_W;

    logic [SEL_W-1:0]  sel_q;
    logic [ST_W-1:0]   lfsr_q;
    logic [ST_W-1:0]   base_seed;
    logic              sel_change;
    logic              cfg_ok;
    mode_e             st_d;

    logic [WIDE_W-1:0] eng_word [NUM_PAT];
    logic [ST_W-1:0]   eng_nw   [NUM_PAT];
    logic [ST_W-1:0]   eng_nn   [NUM_PAT];

    logic [WIDE_W-1:0] pick_word;
    logic [ST_W-1:0]   pick_nw;
    logic [ST_W-1:0]   pick_nn;

    prbs_cfg_check u_cfg (
        .pattern_sel (pattern_sel),
        .width_sel   (width_sel),
        .cfg_ok      (cfg_ok)
    );

    prbs_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_ok    (cfg_ok),
        .st_d      (st_d),
        .run_now   (data_valid),
        .fault_now (config_error)
    );

    // reseed to all ones whenever the pattern code moves
    always_comb begin
        sel_change = (pattern_sel != sel_q);
        base_seed  = sel_change ? '1 : lfsr_q;
    end

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_eng
        localparam int L = pat_len(g);
        localparam int T = pat_tap(g);
        prbs_lfsr_unroll #(
            .LEN      (L),
            .TAP      (T),
            .STORE_W  (ST_W),
            .WIDE_W   (WIDE_W),
            .NARROW_W (NARROW_W)
        ) u_unroll (
            .seed        (base_seed[L-1:0]),
            .word        (eng_word[g]),
            .next_wide   (eng_nw[g]),
            .next_narrow (eng_nn[g])
        );
    end

    always_comb begin
        pick_word = '0;
        pick_nw   = '0;
        pick_nn   = '0;
        for (int k = 0; k < NUM_PAT; k++) begin
            if (pattern_sel == SEL_W'(k)) begin
                pick_word = eng_word[k];
                pick_nw   = eng_nw[k];
                pick_nn   = eng_nn[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            lfsr_q   <= '1;
            data_out <= '0;
        end else begin
            sel_q <= pattern_sel;
            if (st_d == ST_RUN) begin
                if (width_sel) begin
                    lfsr_q   <= pick_nw;
                    data_out <= pick_word;
                end else begin
                    lfsr_q   <= pick_nn;
                    data_out <= {{PAD_W{1'b0}}, pick_word[NARROW_W-1:0]};
                end
            end else begin
                lfsr_q   <= base_seed;
                data_out <= '0;
            end
        end
    end

endmodule

// File: rtl/prbs_word_gen_sva.sv
module prbs_word_gen_sva #(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [2:0]        pattern_sel,
    input logic              width_sel,
    input logic [WIDE_W-1:0] data_out,
    input logic              data_valid,
    input logic              config_error
);

    logic bad_cfg;
    always_comb bad_cfg = (pattern_sel > 3'd4) || (!width_sel && pattern_sel != 3'd1);

    assert_bad_pair_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cfg |=> config_error);

    assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> (!data_valid && data_out == '0));

    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !bad_cfg) |=> (!data_valid && !config_error && data_out == '0));

    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !width_sel && !bad_cfg) |=> (data_valid && data_out[WIDE_W-1:NARROW_W] == '0));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({data_valid, config_error}) <= 1);

    assert_no_zero_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> data_out != '0);

endmodule

bind prbs_word_gen prbs_word_gen_sva #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .pattern_sel  (pattern_sel),
    .width_sel    (width_sel),
    .data_out     (data_out),
    .data_valid   (data_valid),
    .config_error (config_error)
);

// File: tb/prbs_word_gen_test.sv
`timescale 1ns/1ps
module prbs_word_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  pattern_sel = 3'd0;
    logic        width_sel = 1'b1;
    logic [63:0] data_out;
    logic        data_valid;
    logic        config_error;

    int checks = 0;
    int errors = 0;

    logic [30:0] m_st;
    logic [2:0]  m_prev;
    logic [63:0] last_word;

    always #5 clk = ~clk;

    prbs_word_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .pattern_sel  (pattern_sel),
        .width_sel    (width_sel),
        .data_out     (data_out),
        .data_valid   (data_valid),
        .config_error (config_error)
    );

    function automatic int blen(input logic [2:0] s);
        case (s)
            3'd0: return 7;
            3'd1: return 9;
            3'd2: return 15;
            3'd3: return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int btap(input logic [2:0] s);
        case (s)
            3'd0: return 6;
            3'd1: return 5;
            3'd2: return 14;
            3'd3: return 18;
            default: return 28;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive, advance the model, compare (R10: one edge of latency)
    task automatic cycle(input logic en, input logic [2:0] sel, input logic wide, input string tag);
        logic [63:0] exp;
        logic        ok;
        logic        fb;
        int          n;
        @(negedge clk);
        enable = en; pattern_sel = sel; width_sel = wide;
        if (sel != m_prev) m_st = '1;
        m_prev = sel;
        ok  = (sel == 3'd1) || (wide && sel <= 3'd4);
        exp = '0;
        if (ok && en) begin
            n = wide ? 64 : 10;
            for (int i = 0; i < n; i++) begin
                fb = m_st[blen(sel)-1] ^ m_st[btap(sel)-1];
                exp[i] = fb;
                m_st = {m_st[29:0], fb};
            end
        end
        @(posedge clk);
        #1;
        check(data_out == exp, {tag, " data"}, data_out, exp);
        check(data_valid == (ok && en), {tag, " valid"}, 64'(data_valid), 64'(ok && en));
        check(config_error == !ok, {tag, " error"}, 64'(config_error), 64'(!ok));
        if (ok && en) check(data_out != '0, "R11 nonzero", data_out, 64'd1);
        last_word = data_out;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        check(data_out == '0, "R6 reset data", data_out, '0);
        check(!data_valid && !config_error, "R6 reset flags",
              64'({data_valid, config_error}), '0);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = '1;
        m_prev = 3'd0;
    endtask

    task automatic t_prbs7_start;
        cycle(1'b1, 3'd0, 1'b1, "R1 R2 prbs7 first");
        check(last_word[6:0] == 7'b1000000, "R2 prbs7 known prefix", 64'(last_word[6:0]), 64'h40);
        for (int i = 0; i < 3; i++) cycle(1'b1, 3'd0, 1'b1, "R8 prbs7 continue");
    endtask

    task automatic t_prbs9_narrow_period;
        logic [63:0] first;
        cycle(1'b1, 3'd1, 1'b0, "R7 R3 prbs9 narrow reseed");
        first = last_word;
        for (int i = 0; i < 510; i++) cycle(1'b1, 3'd1, 1'b0, "R3 prbs9 narrow");
        cycle(1'b1, 3'd1, 1'b0, "R2 prbs9 period");
        check(last_word == first, "R2 prbs9 repeats after 511 words", last_word, first);
    endtask

    task automatic t_width_switch;
        cycle(1'b1, 3'd1, 1'b1, "R8 narrow to wide");
        cycle(1'b1, 3'd1, 1'b0, "R8 wide to narrow");
        cycle(1'b1, 3'd1, 1'b1, "R8 narrow to wide again");
    endtask

    task automatic t_enable_gap;
        for (int i = 0; i < 3; i++) cycle(1'b0, 3'd1, 1'b1, "R9 disabled");
        cycle(1'b1, 3'd1, 1'b1, "R9 resume holds state");
    endtask

    task automatic t_fault_hold;
        cycle(1'b1, 3'd0, 1'b1, "R7 prbs7 reseed");
        cycle(1'b1, 3'd0, 1'b1, "R8 prbs7 run");
        cycle(1'b1, 3'd0, 1'b0, "R4 R5 prbs7 narrow illegal");
        cycle(1'b0, 3'd0, 1'b0, "R5 fault while disabled");
        cycle(1'b1, 3'd0, 1'b1, "R5 state held through fault");
    endtask

    task automatic t_bad_codes;
        cycle(1'b1, 3'd5, 1'b1, "R1 code5 unsupported");
        cycle(1'b1, 3'd7, 1'b0, "R1 code7 unsupported");
        cycle(1'b1, 3'd6, 1'b1, "R1 code6 unsupported");
        cycle(1'b1, 3'd2, 1'b0, "R4 prbs15 narrow illegal");
    endtask

    task automatic t_long_patterns;
        for (int i = 0; i < 4; i++) cycle(1'b1, 3'd2, 1'b1, "R1 prbs15 wide");
        for (int i = 0; i < 4; i++) cycle(1'b1, 3'd3, 1'b1, "R1 prbs23 wide");
        for (int i = 0; i < 4; i++) cycle(1'b1, 3'd4, 1'b1, "R1 prbs31 wide");
        cycle(1'b1, 3'd4, 1'b0, "R4 prbs31 narrow illegal");
        cycle(1'b1, 3'd4, 1'b1, "R5 prbs31 resumes");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_prbs7_start();
        t_prbs9_narrow_period();
        t_width_switch();
        t_enable_gap();
        t_fault_hold();
        t_bad_codes();
        t_long_patterns();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule